// File: doc/BRIEF.md
# Dual-Strobe DRAM Cycle Decoder

This block is the control front end on the device side of a byte-strobed dynamic memory. It samples the active-low row strobe, the two byte column strobes, the write and output-enable controls and the multiplexed address on every clock. From these it forms one internal column strobe and classifies each row-strobe cycle. It also latches the row and column addresses, keeps the refresh row counter, and produces per-byte drive-enable and write-enable lanes for the data path and array, which sit outside this block.

The internal column strobe is active while either byte strobe is low. It therefore starts with the first byte strobe to fall and ends with the last one to rise. The order of the edges sets the cycle type:

- A column strobe already low when the row strobe falls starts a refresh from the internal counter.
- A row strobe with no column strobe refreshes the addressed row.
- A write control that is already low when the column strobe falls makes an early write.
- A write control that falls later makes a late write.

When the cycle ends, the decoder reports its type for one clock.

Top module: `dram_strobe_decoder`

## Requirements
- R1: The internal column strobe is active while either byte strobe is low. The column address is latched at the first byte strobe to fall, a later fall of the other strobe does not re-latch it, and the cycle cannot end while either byte strobe is still low.
- R2: Lane bit 0 of `out_en` and `wr_en` covers data bits 7:0 and follows `lcas_n` only. Lane bit 1 covers data bits 15:8 and follows `ucas_n` only.
- R3: If the internal column strobe is active when `ras_n` is sampled low, the cycle is a counter refresh. `row_q` takes the counter value and ignores `addr`, and the counter then steps by one, wrapping modulo 256.
- R4: A cycle in which `ras_n` goes low and rises again with both byte strobes high is a row-only refresh. `row_q` holds the address sampled with the row strobe fall, and no lane drives or writes.
- R5: If `we_n` is low when the column strobe falls, the cycle is an early write. `wr_en` follows the active lanes, and `out_en` stays 0 for the rest of the cycle, even with `oe_n` low and after `we_n` rises.
- R6: If `we_n` falls after the column strobe with `oe_n` high, the cycle becomes a late write. `wr_en` follows the active lanes and `out_en` stays 0.
- R7: In a read, a lane drives only while `we_n` is high, `oe_n` is low and that lane's strobe is low. Raising `oe_n` while the strobe is still low turns the lane off.
- R8: With `ras_n`, `lcas_n` and `ucas_n` all high, `out_en` and `wr_en` are 0.
- R9: When a cycle ends with all three strobes high, `cyc_done` is 1 for exactly one clock and `cyc_kind` gives the type: 1 read, 2 early write, 3 late write, 4 row-only refresh, 5 counter refresh. At all other times `cyc_kind` is 0.
- R10: Within one row-strobe-low period, each new fall of the internal column strobe latches a new column address.
- R11: After reset, `out_en`, `wr_en`, `cyc_done`, `cyc_kind` and `rfsh_cnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower byte column strobe, active low |
| ucas_n | input | 1 | Upper byte column strobe, active low |
| we_n | input | 1 | Write control, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 8 | Multiplexed row/column address |
| cyc_done | output | 1 | One-clock pulse at the end of a cycle |
| cyc_kind | output | 3 | Type of the ending cycle, 0 when no cycle ends |
| row_q | output | 8 | Row of the current or last cycle |
| col_q | output | 8 | Latest latched column |
| rfsh_cnt | output | 8 | Next row for a counter refresh |
| out_en | output | 2 | Per-byte drive enable, bit 0 for the lower byte |
| wr_en | output | 2 | Per-byte write enable, bit 0 for the lower byte |

## Verification
Some rules are checked on every clock by properties:

- a lane's drive or write enable always matches the sampled strobe, write and output-enable levels;
- driving and writing never happen together;
- everything is quiet when all strobes are high;
- the end pulse lasts one clock, follows an all-high sample and carries a legal code;
- the refresh counter only ever steps by one.

Other rules depend on the order of edges, and only the bench scenarios can show them:

- the cycle type chosen from that order;
- the early write staying quiet after the write control rises;
- the column held across a staggered second strobe fall and re-latched on a page-mode fall;
- the address being ignored during a counter refresh;
- the counter wrapping.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_READ  = 3'd1,
    K_EWR   = 3'd2,
    K_LWR   = 3'd3,
    K_RONLY = 3'd4,
    K_CBR   = 3'd5
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ROW,
    S_COL,
    S_RFSH
  } st_e;
endpackage

// File: rtl/dsd_sampler.sv
module dsd_sampler #(
  parameter int AW    = 8,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic [LANES-1:0] cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [AW-1:0]    addr,
  output logic             s_ras_n,
  output logic [LANES-1:0] s_cas_n,
  output logic             s_we_n,
  output logic             s_oe_n,
  output logic [AW-1:0]    s_addr,
  output logic             cas_any
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ras_n <= 1'b1;
      s_cas_n <= '1;
      s_we_n  <= 1'b1;
      s_oe_n  <= 1'b1;
      s_addr  <= '0;
    end else begin
      s_ras_n <= ras_n;
      s_cas_n <= cas_n;
      s_we_n  <= we_n;
      s_oe_n  <= oe_n;
      s_addr  <= addr;
    end
  end

  // merged strobe: active from first lane low until last lane high
  assign cas_any = ~(&s_cas_n);
endmodule

// File: rtl/dsd_refresh_ctr.sv
module dsd_refresh_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (step) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dsd_cycle_fsm.sv
module dsd_cycle_fsm
  import dsd_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_ras_n,
  input  logic          cas_any,
  input  logic          s_we_n,
  input  logic [AW-1:0] s_addr,
  input  logic [AW-1:0] rcnt,
  output logic          ctr_step,
  output logic          in_col,
  output logic          kind_read,
  output logic          done,
  output kind_e         kind_out,
  output logic [AW-1:0] row_q,
  output logic [AW-1:0] col_q
);
  st_e           st_q, st_d;
  kind_e         kind_q, kind_d;
  logic [AW-1:0] row_r, row_d, col_r, col_d;
  logic          cas_prev_q;
  logic          cas_fall;

  assign cas_fall = cas_any & ~cas_prev_q;

  always_comb begin
    st_d     = st_q;
    kind_d   = kind_q;
    row_d    = row_r;
    col_d    = col_r;
    ctr_step = 1'b0;
    done     = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (!s_ras_n) begin
          if (cas_any) begin
            st_d     = S_RFSH;
            kind_d   = K_CBR;
            row_d    = rcnt;
            ctr_step = 1'b1;
          end else begin
            st_d   = S_ROW;
            kind_d = K_RONLY;
            row_d  = s_addr;
          end
        end
      end
      S_ROW: begin
        if (s_ras_n) begin
          done = 1'b1;
          st_d = S_IDLE;
        end else if (cas_any) begin
          st_d   = S_COL;
          col_d  = s_addr;
          kind_d = s_we_n ? K_READ : K_EWR;
        end
      end
      S_COL: begin
        if (s_ras_n && !cas_any) begin
          done = 1'b1;
          st_d = S_IDLE;
        end else begin
          if (cas_fall && !s_ras_n) col_d = s_addr;
          if (kind_q == K_READ && !s_we_n && cas_any) kind_d = K_LWR;
        end
      end
      S_RFSH: begin
        if (s_ras_n && !cas_any) begin
          done = 1'b1;
          st_d = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      kind_q     <= K_NONE;
      row_r      <= '0;
      col_r      <= '0;
      cas_prev_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      kind_q     <= kind_d;
      row_r      <= row_d;
      col_r      <= col_d;
      cas_prev_q <= cas_any;
    end
  end

  assign in_col    = (st_q == S_COL);
  assign kind_read = (kind_q == K_READ);
  assign kind_out  = done ? kind_q : K_NONE;
  assign row_q     = row_r;
  assign col_q     = col_r;
endmodule

// File: rtl/dsd_lane_ctl.sv
module dsd_lane_ctl #(
  parameter int LANES = 2
) (
  input  logic             in_col,
  input  logic             kind_read,
  input  logic [LANES-1:0] s_cas_n,
  input  logic             s_we_n,
  input  logic             s_oe_n,
  output logic [LANES-1:0] out_en,
  output logic [LANES-1:0] wr_en
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign out_en[g] = in_col & kind_read & s_we_n & ~s_oe_n & ~s_cas_n[g];
    assign wr_en[g]  = in_col & ~s_we_n & ~s_cas_n[g];
  end
endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
  import dsd_pkg::*;
#(
  parameter int AW = 8,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          lcas_n,
  input  logic          ucas_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  output logic          cyc_done,
  output logic [2:0]    cyc_kind,
  output logic [AW-1:0] row_q,
  output logic [AW-1:0] col_q,
  output logic [RW-1:0] rfsh_cnt,
  output logic [1:0]    out_en,
  output logic [1:0]    wr_en
);
  localparam int LANES = 2;

  logic [1:0]       rs_q;
  logic             rst_i_n;
  logic             s_ras_n, s_we_n, s_oe_n, cas_any;
  logic [LANES-1:0] s_cas_n;
  logic [AW-1:0]    s_addr;
  logic [RW-1:0]    cnt;
  logic             ctr_step, in_col, kind_read;
  kind_e            kind_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  dsd_sampler #(.AW(AW), .LANES(LANES)) u_smp (
    .clk(clk), .rst_n(rst_i_n), .ras_n(ras_n), .cas_n({ucas_n, lcas_n}),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .s_ras_n(s_ras_n),
    .s_cas_n(s_cas_n), .s_we_n(s_we_n), .s_oe_n(s_oe_n),
    .s_addr(s_addr), .cas_any(cas_any)
  );

  dsd_refresh_ctr #(.W(RW)) u_ctr (
    .clk(clk), .rst_n(rst_i_n), .step(ctr_step), .cnt(cnt)
  );

  dsd_cycle_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_i_n), .s_ras_n(s_ras_n), .cas_any(cas_any),
    .s_we_n(s_we_n), .s_addr(s_addr), .rcnt(AW'(cnt)),
    .ctr_step(ctr_step), .in_col(in_col), .kind_read(kind_read),
    .done(cyc_done), .kind_out(kind_out), .row_q(row_q), .col_q(col_q)
  );

  dsd_lane_ctl #(.LANES(LANES)) u_lane (
    .in_col(in_col), .kind_read(kind_read), .s_cas_n(s_cas_n),
    .s_we_n(s_we_n), .s_oe_n(s_oe_n), .out_en(out_en), .wr_en(wr_en)
  );

  assign cyc_kind = kind_out;
  assign rfsh_cnt = cnt;
endmodule

// File: rtl/dsd_checker.sv
module dsd_checker #(
  parameter int AW = 8,
  parameter int RW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          lcas_n,
  input logic          ucas_n,
  input logic          we_n,
  input logic          oe_n,
  input logic [AW-1:0] addr,
  input logic          cyc_done,
  input logic [2:0]    cyc_kind,
  input logic [AW-1:0] row_q,
  input logic [AW-1:0] col_q,
  input logic [RW-1:0] rfsh_cnt,
  input logic [1:0]    out_en,
  input logic [1:0]    wr_en
);
  p_drive_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_en[0] |-> $past(we_n && !oe_n && !lcas_n));

  p_drive_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_en[1] |-> $past(we_n && !oe_n && !ucas_n));

  p_write_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[0] |-> $past(!we_n && !lcas_n));

  p_write_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[1] |-> $past(!we_n && !ucas_n));

  p_no_contend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en != 2'b00) |-> (out_en == 2'b00));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ras_n && lcas_n && ucas_n) |-> (out_en == 2'b00 && wr_en == 2'b00));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> $past(ras_n && lcas_n && ucas_n));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done);

  p_done_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> (cyc_kind >= 3'd1 && cyc_kind <= 3'd5));

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_cnt != $past(rfsh_cnt)) |-> (rfsh_cnt == RW'($past(rfsh_cnt) + RW'(1))));
endmodule

bind dram_strobe_decoder dsd_checker #(.AW(AW), .RW(RW)) u_chk (.*);

// File: tb/dram_strobe_decoder_tb.sv
module dram_strobe_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ras_n, lcas_n, ucas_n, we_n, oe_n;
  logic [7:0] addr;
  logic       cyc_done;
  logic [2:0] cyc_kind;
  logic [7:0] row_q, col_q, rfsh_cnt;
  logic [1:0] out_en, wr_en;

  int   total = 0;
  int   bad = 0;
  bit   fin = 0;
  logic [7:0] exp_cnt = 8'd0;

  always #10 clk = ~clk;

  dram_strobe_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n),
    .ucas_n(ucas_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .cyc_done(cyc_done), .cyc_kind(cyc_kind), .row_q(row_q),
    .col_q(col_q), .rfsh_cnt(rfsh_cnt), .out_en(out_en), .wr_en(wr_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [2:0] exp_kind(input int typ);
    case (typ)
      0: return 3'd1;
      1: return 3'd2;
      2: return 3'd3;
      3: return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  task automatic set_cas(input logic [1:0] ln);
    lcas_n = ~ln[0];
    ucas_n = ~ln[1];
  endtask

  task automatic finish_cycle(input logic [2:0] k);
    ras_n = 1'b1; lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    step(1);
    chk("R9 end pulse", cyc_done, 1'b1);
    chk("R9 kind code", cyc_kind, k);
    step(1);
    chk("R9 single pulse", cyc_done, 1'b0);
    chk("R8 idle quiet", {out_en, wr_en}, 4'h0);
  endtask

  // typ: 0 read, 1 early write, 2 late write, 3 row-only refresh, 4 counter refresh
  task automatic run_cycle(input int typ, input logic [7:0] r, input logic [7:0] c,
                           input logic [1:0] ln);
    case (typ)
      0: begin
        ras_n = 1'b0; addr = r; step(2);
        we_n = 1'b1; oe_n = 1'b0; addr = c; set_cas(ln); step(2);
        chk("R7 read lanes", out_en, ln);
        chk("R2 read no write", wr_en, 2'b00);
        chk("R4 row latch", row_q, r);
        chk("R1 column latch", col_q, c);
        oe_n = 1'b1; step(2);
        chk("R7 oe high off", out_en, 2'b00);
      end
      1: begin
        ras_n = 1'b0; addr = r; step(2);
        we_n = 1'b0; oe_n = 1'b0; step(1);
        addr = c; set_cas(ln); step(2);
        chk("R5 early write lanes", wr_en, ln);
        chk("R5 early no drive", out_en, 2'b00);
        we_n = 1'b1; step(2);
        chk("R5 still off after we rise", out_en, 2'b00);
      end
      2: begin
        ras_n = 1'b0; addr = r; step(2);
        we_n = 1'b1; oe_n = 1'b1; addr = c; set_cas(ln); step(2);
        chk("R6 before we fall", wr_en, 2'b00);
        we_n = 1'b0; step(2);
        chk("R6 late write lanes", wr_en, ln);
        chk("R6 late no drive", out_en, 2'b00);
      end
      3: begin
        ras_n = 1'b0; addr = r; step(2);
        chk("R4 no drive", out_en, 2'b00);
        chk("R4 no write", wr_en, 2'b00);
        step(1);
        ras_n = 1'b1; step(1);
        chk("R9 end pulse", cyc_done, 1'b1);
        chk("R4 kind", cyc_kind, 3'd4);
        chk("R4 row", row_q, r);
        step(1);
        chk("R9 single pulse", cyc_done, 1'b0);
        return;
      end
      default: begin
        set_cas(ln); step(2);
        chk("R9 no end while idle", cyc_done, 1'b0);
        ras_n = 1'b0; addr = r; step(2);
        chk("R3 row from counter", row_q, exp_cnt);
        chk("R3 counter step", rfsh_cnt, 8'(exp_cnt + 8'd1));
        chk("R3 no drive", out_en, 2'b00);
        exp_cnt = exp_cnt + 8'd1;
      end
    endcase
    finish_cycle(exp_kind(typ));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    ras_n = 1'b1; lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    addr = 8'h00;
    step(5);
    rst_n = 1'b1;
    step(4);
    chk("R11 out_en", out_en, 2'b00);
    chk("R11 wr_en", wr_en, 2'b00);
    chk("R11 done", cyc_done, 1'b0);
    chk("R11 kind", cyc_kind, 3'd0);
    chk("R11 counter", rfsh_cnt, 8'h00);

    // R2 single lanes
    run_cycle(0, 8'h12, 8'h34, 2'b01);
    run_cycle(0, 8'h56, 8'h78, 2'b10);
    run_cycle(1, 8'h9a, 8'hbc, 2'b10);
    run_cycle(2, 8'hde, 8'hf0, 2'b01);

    // R1 staggered strobes: first fall latches, last rise ends
    ras_n = 1'b0; addr = 8'h21; step(2);
    we_n = 1'b1; oe_n = 1'b0; lcas_n = 1'b0; addr = 8'h43; step(2);
    addr = 8'h65; ucas_n = 1'b0; step(2);
    chk("R1 second fall no relatch", col_q, 8'h43);
    chk("R2 both lanes", out_en, 2'b11);
    ras_n = 1'b1; ucas_n = 1'b1; step(1);
    chk("R1 no end while lcas low", cyc_done, 1'b0);
    step(1);
    chk("R1 no end while lcas low", cyc_done, 1'b0);
    chk("R2 lower lane only", out_en, 2'b01);
    lcas_n = 1'b1; step(1);
    chk("R1 end on last rise", cyc_done, 1'b1);
    chk("R9 kind read", cyc_kind, 3'd1);
    oe_n = 1'b1; step(1);
    chk("R9 single pulse", cyc_done, 1'b0);

    // R10 page mode
    ras_n = 1'b0; addr = 8'h07; step(2);
    addr = 8'h11; set_cas(2'b11); step(2);
    set_cas(2'b00); step(2);
    chk("R10 no end with ras low", cyc_done, 1'b0);
    addr = 8'h99; set_cas(2'b11); step(2);
    chk("R10 new column", col_q, 8'h99);
    finish_cycle(3'd1);

    // R3 address ignored, counter refreshes
    run_cycle(4, 8'hff, 8'h00, 2'b01);
    run_cycle(4, 8'h3c, 8'h00, 2'b10);

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      int typ;
      logic [1:0] ln;
      typ = int'($urandom_range(4, 0));
      ln  = 2'($urandom_range(3, 1));
      run_cycle(typ, 8'($urandom), 8'($urandom), ln);
    end

    // R3 wrap: 256 more counter refreshes return to the same value
    begin
      logic [7:0] start;
      start = exp_cnt;
      for (int i = 0; i < 256; i++) run_cycle(4, 8'($urandom), 8'h00, 2'b11);
      chk("R3 wrap modulo 256", rfsh_cnt, start);
    end

    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule